// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block is the receive engine of a serial adapter. It watches one serial data line that idles high and uses a receive clock enable to pace itself. It finds the low start bit, then collects the data bits least significant bit first, then an optional parity bit, then the stop bit. It hands the result to the host as a parallel character, together with status flags for that character.

The host sets two things at run time. The first is the number of receive clock enables that make one bit time: 1, 16 or 64. The second is the character format: seven or eight data bits, and even, odd or no parity. In the oversampled modes a start edge is checked again half a bit later, which rejects short low glitches. Every later bit is sampled at its centre. In the divide-by-one mode the line is taken to be synchronous to the receive clock, so each bit is sampled on a single enable.

The block marks a completed character as available and holds it until the host takes it. It reports a framing error, a parity error and an overrun as separate flags. On an overrun the new character is dropped and the held one is kept.

Top module: `sci_rx`

## Requirements
- R1: After reset, `rx_full`, `err_frame`, `err_parity` and `err_overrun` are 0 and `rx_data` is 0.
- R2: A character is a low start bit, then the data bits least significant bit first, then an optional parity bit, then a high stop bit. After the stop bit has been sampled, `rx_data` holds the data bits and `rx_full` is 1.
- R3: Bit 2 of `fmt` sets the data length: 1 means eight data bits and 0 means seven. With seven data bits, bit 7 of `rx_data` reads 0.
- R4: Bits 1:0 of `fmt` set the parity: 01 is even, 10 is odd, and 00 or 11 means no parity bit. Parity is computed over the data bits only. `err_parity` is 1 for a delivered character whose parity bit does not match.
- R5: `err_frame` is 1 for a delivered character whose stop bit sampled low. Only the first stop bit is examined.
- R6: `div_sel` sets the bit time: 00 is 1 receive enable per bit, 01 is 16 and 10 is 64. The value 11 holds the engine idle, and no character is received while it is set.
- R7: At divide 16 and 64, the line is sampled again half a bit after the start edge. If it is high there, the start is treated as noise and the engine returns to idle without delivering a character.
- R8: A one-cycle pulse on `take` clears `rx_full` and `err_overrun` on the next clock.
- R9: If a character completes while `rx_full` is 1 and `take` is not asserted, `err_overrun` becomes 1. The new character is discarded, and `rx_data` keeps the earlier character.
- R10: The receive state does not advance while `rx_en` is low. A low level on the line with no enable pulses starts no reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive clock enable, one pulse per receive clock |
| rx_line | input | 1 | Serial data line, idles high |
| div_sel | input | 2 | Bit time select: 00 = 1, 01 = 16, 10 = 64, 11 = held idle |
| fmt | input | 3 | Format: bit 2 = eight data bits; bits 1:0 = 01 even, 10 odd, other values no parity |
| take | input | 1 | Host takes the held character |
| rx_data | output | 8 | Received character |
| rx_full | output | 1 | A character is waiting for the host |
| err_frame | output | 1 | Stop bit of the held character sampled low |
| err_parity | output | 1 | Parity mismatch in the held character |
| err_overrun | output | 1 | A character was lost because the held one had not been taken |

## Verification
A table of characters is sent at all three bit times. It mixes seven-bit and eight-bit formats, all parity choices, and data patterns with the top bit set. This separates true least-significant-bit-first collection and correct masking of the top bit from a shift in the wrong direction or an off-by-one bit count. Some entries flip the parity bit and others send a low stop bit. These show that the two error flags follow their own causes and do not leak into each other. Directed tests then cover the remaining cases: a start glitch shorter than half a bit, a low line held while no enables arrive, the idle divider code, and a second character arriving before the first was taken. Each shows whether a guard stops the engine or lets a false or lost character through.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_t;

   localparam logic [1:0] DIV_ONE  = 2'b00;
   localparam logic [1:0] DIV_MID  = 2'b01;
   localparam logic [1:0] DIV_HIGH = 2'b10;
   localparam logic [1:0] DIV_OFF  = 2'b11;

   localparam logic [1:0] PAR_EVEN = 2'b01;
   localparam logic [1:0] PAR_ODD  = 2'b10;

   function automatic logic parity_on(input logic [1:0] code);
      return (code == PAR_EVEN) || (code == PAR_ODD);
   endfunction

endpackage

// File: rtl/sci_rx_sync.sv
module sci_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe <= '1;
            else        pipe <= d;
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], d};
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/sci_rx_pace.sv
module sci_rx_pace #(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          hold,
   input  logic [CW-1:0] limit,
   output logic          hit
);
   logic [CW-1:0] cnt;

   assign hit = tick && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     cnt <= CW'(1);
      else if (hold)  cnt <= CW'(1);
      else if (hit)   cnt <= CW'(1);
      else if (tick)  cnt <= cnt + CW'(1);
endmodule

// File: rtl/sci_rx_check.sv
module sci_rx_check #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] raw,
   input  logic              full_len,
   input  logic [1:0]        par_code,
   input  logic              par_bit,
   output logic [DATA_W-1:0] word,
   output logic              par_bad
);
   import sci_rx_pkg::*;

   logic [DATA_W-1:0] short_word;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_short
         if (i == DATA_W - 1) begin : g_top
            assign short_word[i] = 1'b0;
         end else begin : g_low
            assign short_word[i] = raw[i+1];
         end
      end
   endgenerate

   assign word = full_len ? raw : short_word;

   always_comb begin
      par_bad = 1'b0;
      if (parity_on(par_code))
         par_bad = ((^word) ^ par_bit) != (par_code == PAR_ODD);
   end
endmodule

// File: rtl/sci_rx.sv
module sci_rx #(
   parameter int DATA_W      = 8,
   parameter int MID_DIV     = 16,
   parameter int HIGH_DIV    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rx_line,
   input  logic [1:0]        div_sel,
   input  logic [2:0]        fmt,
   input  logic              take,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              err_frame,
   output logic              err_parity,
   output logic              err_overrun
);
   import sci_rx_pkg::*;

   localparam int CW = $clog2(HIGH_DIV + 1);
   localparam int BW = $clog2(DATA_W);
   localparam logic [BW-1:0] LAST_LONG  = BW'(DATA_W - 1);
   localparam logic [BW-1:0] LAST_SHORT = BW'(DATA_W - 2);

   generate
      if (DATA_W < 2)
         $error("sci_rx: DATA_W must be at least 2");
      if (SYNC_STAGES < 1)
         $error("sci_rx: SYNC_STAGES must be at least 1");
      if ((MID_DIV < 2) || (MID_DIV % 2 != 0))
         $error("sci_rx: MID_DIV must be even and at least 2");
      if ((HIGH_DIV < MID_DIV) || (HIGH_DIV % 2 != 0))
         $error("sci_rx: HIGH_DIV must be even and not below MID_DIV");
   endgenerate

   rx_state_t         st;
   logic              line_s;
   logic              hit;
   logic [CW-1:0]     n_ticks;
   logic [CW-1:0]     limit;
   logic [BW-1:0]     bitn;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   logic [DATA_W-1:0] word;
   logic              par_bad;
   logic              off;

   sci_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (line_s)
   );

   always_comb begin
      case (div_sel)
         DIV_ONE:  n_ticks = CW'(1);
         DIV_MID:  n_ticks = CW'(MID_DIV);
         default:  n_ticks = CW'(HIGH_DIV);
      endcase
   end

   assign off   = (div_sel == DIV_OFF);
   assign limit = (st == ST_START) ? (n_ticks >> 1) : n_ticks;

   sci_rx_pace #(.CW(CW)) u_pace (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (rx_en),
      .hold  (st == ST_IDLE),
      .limit (limit),
      .hit   (hit)
   );

   sci_rx_check #(.DATA_W(DATA_W)) u_check (
      .raw      (shreg),
      .full_len (fmt[2]),
      .par_code (fmt[1:0]),
      .par_bit  (pbit),
      .word     (word),
      .par_bad  (par_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         bitn        <= '0;
         shreg       <= '0;
         pbit        <= 1'b0;
         rx_data     <= '0;
         rx_full     <= 1'b0;
         err_frame   <= 1'b0;
         err_parity  <= 1'b0;
         err_overrun <= 1'b0;
      end else begin
         if (take) begin
            rx_full     <= 1'b0;
            err_overrun <= 1'b0;
         end
         if (off) begin
            st <= ST_IDLE;
         end else begin
            case (st)
               ST_IDLE: begin
                  bitn <= '0;
                  if (rx_en && !line_s)
                     st <= (div_sel == DIV_ONE) ? ST_DATA : ST_START;
               end
               ST_START: begin
                  if (hit)
                     st <= line_s ? ST_IDLE : ST_DATA;
               end
               ST_DATA: begin
                  if (hit) begin
                     shreg <= {line_s, shreg[DATA_W-1:1]};
                     bitn  <= bitn + BW'(1);
                     if (bitn == (fmt[2] ? LAST_LONG : LAST_SHORT))
                        st <= parity_on(fmt[1:0]) ? ST_PAR : ST_STOP;
                  end
               end
               ST_PAR: begin
                  if (hit) begin
                     pbit <= line_s;
                     st   <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  if (hit) begin
                     st <= ST_IDLE;
                     if (rx_full && !take) begin
                        err_overrun <= 1'b1;
                     end else begin
                        rx_data    <= word;
                        rx_full    <= 1'b1;
                        err_frame  <= !line_s;
                        err_parity <= par_bad;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/sci_rx_chk.sv
module sci_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rx_en,
   input logic [1:0]            div_sel,
   input logic [2:0]            fmt,
   input logic                  take,
   input logic [DATA_W-1:0]     rx_data,
   input logic                  rx_full,
   input logic                  err_overrun,
   input sci_rx_pkg::rx_state_t st
);
   import sci_rx_pkg::*;

   p_full_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(rx_en));

   p_short_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_full) && !$past(fmt[2])) |-> !rx_data[DATA_W-1]);

   p_off_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (div_sel == DIV_OFF) |=> (st == ST_IDLE));

   p_take_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !rx_en) |=> (!rx_full && !err_overrun));

   p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overrun) |-> ($stable(rx_data) && rx_full));

   p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !take && (div_sel != DIV_OFF)) |=> ($stable(st) && $stable(rx_full)));

endmodule

bind sci_rx sci_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_en       (rx_en),
   .div_sel     (div_sel),
   .fmt         (fmt),
   .take        (take),
   .rx_data     (rx_data),
   .rx_full     (rx_full),
   .err_overrun (err_overrun),
   .st          (st)
);

// File: tb/sci_rx_tb_top.sv
module sci_rx_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       rx_line = 1'b1;
   logic [1:0] div_sel = 2'b01;
   logic [2:0] fmt = 3'b100;
   logic       take = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, err_frame, err_parity, err_overrun;

   logic       gate = 1'b1;
   logic [1:0] tcnt = '0;
   int         n_checks = 0;
   int         n_fail = 0;

   always #2 clk = ~clk;

   always @(negedge clk) begin
      tcnt  <= tcnt + 2'd1;
      rx_en <= gate && (tcnt == 2'd3);
   end

   sci_rx dut_i (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_line(rx_line),
      .div_sel(div_sel), .fmt(fmt), .take(take), .rx_data(rx_data),
      .rx_full(rx_full), .err_frame(err_frame), .err_parity(err_parity),
      .err_overrun(err_overrun)
   );

   // {div, fmt, data, stop, flip parity, expected data, expected frame, expected parity}
   localparam logic [24:0] VEC [10] = '{
      {2'b01, 3'b100, 8'hA5, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0},
      {2'b01, 3'b101, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0},
      {2'b01, 3'b110, 8'h81, 1'b1, 1'b1, 8'h81, 1'b0, 1'b1},
      {2'b01, 3'b001, 8'hD5, 1'b1, 1'b0, 8'h55, 1'b0, 1'b0},
      {2'b10, 3'b010, 8'h7F, 1'b1, 1'b0, 8'h7F, 1'b0, 1'b0},
      {2'b00, 3'b100, 8'h5A, 1'b1, 1'b0, 8'h5A, 1'b0, 1'b0},
      {2'b00, 3'b110, 8'h0F, 1'b0, 1'b0, 8'h0F, 1'b1, 1'b0},
      {2'b10, 3'b101, 8'hFF, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1},
      {2'b01, 3'b000, 8'h80, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
      {2'b00, 3'b011, 8'h12, 1'b1, 1'b0, 8'h12, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         while (!rx_en) @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic send(input logic [1:0] dv, input logic [2:0] f, input logic [7:0] d,
                       input logic stop_v, input logic flip);
      int n;
      int nb;
      logic p;
      n  = (dv == 2'b00) ? 1 : (dv == 2'b10) ? 64 : 16;
      nb = f[2] ? 8 : 7;
      p  = ^(f[2] ? d : {1'b0, d[6:0]});
      if (f[1:0] == 2'b10) p = ~p;
      p = p ^ flip;
      div_sel = dv;
      fmt     = f;
      wait_ticks(1);
      rx_line = 1'b0;
      wait_ticks(n);
      for (int i = 0; i < nb; i++) begin
         rx_line = d[i];
         wait_ticks(n);
      end
      if (f[1:0] == 2'b01 || f[1:0] == 2'b10) begin
         rx_line = p;
         wait_ticks(n);
      end
      rx_line = stop_v;
      wait_ticks(n);
      rx_line = 1'b1;
      wait_ticks(2 * n + 2);
   endtask

   task automatic do_take();
      @(negedge clk);
      take = 1'b1;
      @(negedge clk);
      take = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 full", rx_full, 0);
      check("R1 flags", {err_frame, err_parity, err_overrun}, 0);
      check("R1 data", rx_data, 0);

      foreach (VEC[i]) begin
         logic [24:0] v;
         v = VEC[i];
         send(v[24:23], v[22:20], v[19:12], v[11], v[10]);
         check("R2 R6 full", rx_full, 1);
         check("R2 R3 R6 data", rx_data, v[9:2]);
         check("R5 frame", err_frame, v[1]);
         check("R4 parity", err_parity, v[0]);
         do_take();
         check("R8 full cleared", rx_full, 0);
      end

      // R7 short start glitch at divide 16
      div_sel = 2'b01;
      fmt = 3'b100;
      wait_ticks(1);
      rx_line = 1'b0;
      wait_ticks(3);
      rx_line = 1'b1;
      wait_ticks(40);
      check("R7 glitch rejected", rx_full, 0);
      send(2'b01, 3'b100, 8'hC3, 1'b1, 1'b0);
      check("R7 next char", rx_data, 8'hC3);
      do_take();

      // R10 no enables while line low
      gate = 1'b0;
      @(negedge clk);
      rx_line = 1'b0;
      repeat (200) @(negedge clk);
      rx_line = 1'b1;
      repeat (4) @(negedge clk);
      gate = 1'b1;
      wait_ticks(40);
      check("R10 no reception", rx_full, 0);

      // R6 divider code 11 keeps the engine idle
      send(2'b11, 3'b100, 8'h66, 1'b1, 1'b0);
      check("R6 off mode", rx_full, 0);

      // R9 overrun keeps the first character
      send(2'b01, 3'b100, 8'h11, 1'b1, 1'b0);
      send(2'b01, 3'b100, 8'h22, 1'b1, 1'b0);
      check("R9 overrun", err_overrun, 1);
      check("R9 old data kept", rx_data, 8'h11);
      check("R9 still full", rx_full, 1);
      do_take();
      check("R8 overrun cleared", err_overrun, 0);
      check("R8 full cleared", rx_full, 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule